// File: doc/BRIEF.md
# Bounded Interrupt-Disable Window

This block sits at the writeback stage of a pipeline and applies a short, counted interrupt-disable. When a retiring instruction is a disable command, it carries a small count. The block then cancels the external-interrupt flag on each of that many instructions that retire after it. Those flags were attached to the instructions while they were still in the queue, so no global enable bit is involved. Non-maskable interrupt flags are never touched. The typical use is guarding a code-segment reload and the jump that follows it, with a count of four.

Every retiring instruction arrives with a valid strobe, a tag, an external-interrupt flag and a non-maskable flag. A disable command also sets its own strobe and supplies its count. The block forwards each retiring instruction to the next stage one clock later, with its external-interrupt flag cleared whenever the instruction falls inside an open window. Cycles with no valid retirement do not use up the window.

Top module: `irq_window_guard`

## Requirements
- R1: Each retiring instruction (`ret_valid` high) appears on `wb_valid` and `wb_tag` exactly one clock later. A cycle with `ret_valid` low produces `wb_valid` low one clock later.
- R2: When no window is open, a retiring instruction's external-interrupt flag is forwarded unchanged on `wb_ext_irq`.
- R3: When a window is open, the external-interrupt flag of a retiring instruction is cleared on `wb_ext_irq`.
- R4: `wb_nmi` always equals the non-maskable flag of the instruction retired one clock earlier, whether or not a window is open.
- R5: A disable command with count N (1..7) protects exactly the next N valid retiring instructions. The disable command itself is not covered by its own count, and the instruction after those N is unmasked.
- R6: A disable command with count 0 opens no window, so the next instruction's external flag passes.
- R7: Clock cycles with `ret_valid` low neither consume nor extend an open window.
- R8: When a disable command retires while a window is open, it is itself masked. The window is then set to the larger of two values: the count remaining after this retirement, or the new count.
- R9: Reset is synchronous and active high. It closes any open window and drives `wb_valid`, `wb_ext_irq` and `wb_nmi` low.
- R10: The count field is 3 bits wide, so the largest window, 7, masks seven consecutive following instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_is_di | input | 1 | The retiring instruction is a disable command |
| ret_di_count | input | CNT_W | Number of following instructions to protect |
| ret_ext_irq | input | 1 | External interrupt flag attached to the instruction |
| ret_nmi | input | 1 | Non-maskable interrupt flag attached to the instruction |
| ret_tag | input | TAG_W | Instruction identifier, passed through |
| wb_valid | output | 1 | Registered retirement strobe |
| wb_ext_irq | output | 1 | External flag after masking |
| wb_nmi | output | 1 | Non-maskable flag, never masked |
| wb_tag | output | TAG_W | Registered identifier |

## Verification
A wrong window count shows up on `wb_ext_irq` one clock after the first retirement it affects: either an interrupt that should have survived is dropped, or one that should have been cancelled leaks through. The reference model tracks the remaining count through bubbles, overlapping disable commands and mid-window resets, and compares all four outputs on every clock. An off-by-one error in the decrement or in the reload choice is therefore exposed within at most eight retirements.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  // Interrupt flags carried by a retiring instruction
  typedef struct packed {
    logic ext;
    logic nmi;
  } irq_flags_t;

  // Identity of what the window counter does on a retirement
  typedef enum logic [1:0] {
    WIN_HOLD   = 2'd0,
    WIN_STEP   = 2'd1,
    WIN_RELOAD = 2'd2
  } win_op_e;

endpackage

// File: rtl/iwin_counter.sv
module iwin_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  output logic             win_open,
  output logic [CNT_W-1:0] cnt
);
  import iwin_pkg::*;

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] cnt_nxt;
  win_op_e          op;

  assign win_open = (cnt != ZERO);

  always_comb begin
    if (!adv)      op = WIN_HOLD;
    else if (load) op = WIN_RELOAD;
    else           op = WIN_STEP;
  end

  // Count left once the current retirement has been charged to the window
  always_comb begin
    if (win_open) remaining = cnt - ONE;
    else          remaining = ZERO;
  end

  always_comb begin
    case (op)
      WIN_STEP:   cnt_nxt = remaining;
      WIN_RELOAD: cnt_nxt = (load_cnt > remaining) ? load_cnt : remaining;
      default:    cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= ZERO;
    else     cnt <= cnt_nxt;
  end

endmodule

// File: rtl/iwin_gate.sv
module iwin_gate #(
  parameter int TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  iwin_pkg::irq_flags_t in_flags,
  input  logic [TAG_W-1:0]     in_tag,
  input  logic                 mask_ext,
  output logic                 out_valid,
  output iwin_pkg::irq_flags_t out_flags,
  output logic [TAG_W-1:0]     out_tag
);
  import iwin_pkg::*;

  irq_flags_t flags_nxt;

  always_comb begin
    flags_nxt     = in_flags;
    flags_nxt.ext = in_valid & in_flags.ext & ~mask_ext;
    flags_nxt.nmi = in_valid & in_flags.nmi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flags <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      out_flags <= flags_nxt;
      if (in_valid) out_tag <= in_tag;
    end
  end

endmodule

// File: rtl/irq_window_guard.sv
module irq_window_guard #(
  parameter int CNT_W = 3,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ret_valid,
  input  logic             ret_is_di,
  input  logic [CNT_W-1:0] ret_di_count,
  input  logic             ret_ext_irq,
  input  logic             ret_nmi,
  input  logic [TAG_W-1:0] ret_tag,
  output logic             wb_valid,
  output logic             wb_ext_irq,
  output logic             wb_nmi,
  output logic [TAG_W-1:0] wb_tag
);
  import iwin_pkg::*;

  logic             win_open;
  logic [CNT_W-1:0] win_cnt;
  irq_flags_t       in_flags;
  irq_flags_t       out_flags;

  assign in_flags.ext = ret_ext_irq;
  assign in_flags.nmi = ret_nmi;

  iwin_counter #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .adv      (ret_valid),
    .load     (ret_is_di),
    .load_cnt (ret_di_count),
    .win_open (win_open),
    .cnt      (win_cnt)
  );

  iwin_gate #(.TAG_W(TAG_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ret_valid),
    .in_flags  (in_flags),
    .in_tag    (ret_tag),
    .mask_ext  (win_open),
    .out_valid (wb_valid),
    .out_flags (out_flags),
    .out_tag   (wb_tag)
  );

  assign wb_ext_irq = out_flags.ext;
  assign wb_nmi     = out_flags.nmi;

endmodule

// File: rtl/iwin_checker.sv
module iwin_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ret_valid,
  input logic             ret_is_di,
  input logic [CNT_W-1:0] ret_di_count,
  input logic             ret_ext_irq,
  input logic             ret_nmi,
  input logic [CNT_W-1:0] win_cnt,
  input logic             wb_valid,
  input logic             wb_ext_irq,
  input logic             wb_nmi
);

  p_valid_r1: assert property (@(posedge clk) disable iff (rst)
    ret_valid |=> wb_valid);

  p_bubble_r1: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> !wb_valid);

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_ext_irq && win_cnt == '0) |=> wb_ext_irq);

  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && win_cnt != '0) |=> !wb_ext_irq);

  p_nmi_r4: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_nmi) |=> wb_nmi);

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !ret_is_di && win_cnt != '0) |=> (win_cnt == $past(win_cnt) - CNT_W'(1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ret_valid |=> $stable(win_cnt));

  p_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_is_di && ret_di_count >= win_cnt) |=> (win_cnt == $past(ret_di_count)));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (win_cnt == '0 && !wb_valid && !wb_ext_irq && !wb_nmi));

endmodule

bind irq_window_guard iwin_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ret_valid    (ret_valid),
  .ret_is_di    (ret_is_di),
  .ret_di_count (ret_di_count),
  .ret_ext_irq  (ret_ext_irq),
  .ret_nmi      (ret_nmi),
  .win_cnt      (win_cnt),
  .wb_valid     (wb_valid),
  .wb_ext_irq   (wb_ext_irq),
  .wb_nmi       (wb_nmi)
);

// File: tb/tb_irq_window_guard.sv
module tb_irq_window_guard;
  localparam int CNT_W = 3;
  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ret_valid = 1'b0;
  logic             ret_is_di = 1'b0;
  logic [CNT_W-1:0] ret_di_count = '0;
  logic             ret_ext_irq = 1'b0;
  logic             ret_nmi = 1'b0;
  logic [TAG_W-1:0] ret_tag = '0;
  logic             wb_valid, wb_ext_irq, wb_nmi;
  logic [TAG_W-1:0] wb_tag;

  int total = 0;
  int bad = 0;
  int model_cnt = 0;
  logic [TAG_W-1:0] last_tag = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_window_guard #(.CNT_W(CNT_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .ret_is_di(ret_is_di),
    .ret_di_count(ret_di_count), .ret_ext_irq(ret_ext_irq), .ret_nmi(ret_nmi),
    .ret_tag(ret_tag), .wb_valid(wb_valid), .wb_ext_irq(wb_ext_irq),
    .wb_nmi(wb_nmi), .wb_tag(wb_tag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, compare one clock later
  task automatic step(input bit v, input bit di, input int n, input bit ext,
                      input bit nmi, input string req);
    bit in_win;
    int rem;
    bit e_ext;
    bit e_nmi;
    ret_valid    = v;
    ret_is_di    = di;
    ret_di_count = CNT_W'(n);
    ret_ext_irq  = ext;
    ret_nmi      = nmi;
    ret_tag      = ret_tag + 8'd1;
    in_win = (model_cnt > 0);
    e_ext  = v && ext && !in_win;
    e_nmi  = v && nmi;
    if (v) begin
      last_tag = ret_tag;
      rem = in_win ? model_cnt - 1 : 0;
      model_cnt = (di && n > rem) ? n : rem;
    end
    @(posedge clk);
    @(negedge clk);
    check("R1", "valid", int'(wb_valid), int'(v));
    if (v) check("R1", "tag", int'(wb_tag), int'(last_tag));
    check(req, "ext", int'(wb_ext_irq), int'(e_ext));
    check("R4", "nmi", int'(wb_nmi), int'(e_nmi));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ret_valid = 1'b0;
    ret_is_di = 1'b0;
    ret_ext_irq = 1'b1;
    ret_nmi = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_cnt = 0;
    check("R9", "valid after reset", int'(wb_valid), 0);
    check("R9", "ext after reset", int'(wb_ext_irq), 0);
    check("R9", "nmi after reset", int'(wb_nmi), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: no window, flags pass
    step(1, 0, 0, 1, 0, "R2");
    step(1, 0, 0, 1, 1, "R2");
    // R5: count four, disable command itself unmasked
    step(1, 1, 4, 1, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 1, i[0], "R3");
    step(1, 0, 0, 1, 0, "R5");
    // R6: count zero
    step(1, 1, 0, 1, 0, "R6");
    step(1, 0, 0, 1, 0, "R6");
    // R7: bubbles do not consume the window
    step(1, 1, 2, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R7");
    step(1, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 1, 0, "R7");
    step(1, 0, 0, 1, 0, "R7");
    step(1, 0, 0, 1, 0, "R7");
    // R10: largest count
    step(1, 1, 7, 0, 0, "R10");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 1, 1, "R10");
    step(1, 0, 0, 1, 0, "R10");
    // R8: smaller new count keeps remaining (5 -> 2 left after this retirement)
    step(1, 1, 5, 0, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 1, 1, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    // R8: larger new count extends
    step(1, 1, 2, 0, 0, "R8");
    step(1, 1, 6, 1, 0, "R8");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 1, 0, "R8");
    step(1, 0, 0, 1, 0, "R8");
    // R9: reset in the middle of a window
    step(1, 1, 7, 0, 0, "R9");
    step(1, 0, 0, 1, 0, "R9");
    do_reset();
    step(1, 0, 0, 1, 0, "R9");
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 80, ($urandom_range(0, 5) == 0), $urandom_range(0, 7),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, "R3");
    end
    finish_run();
  end
endmodule